// File: doc/BRIEF.md
# Major and minor state sequencer

This block produces the timing states of a hardwired control unit. A four-position one-hot ring marks the clock slot inside a phase (T0 to T3). A two-bit phase register selects Fetch, Defer or Execute, and the same register also drives a one-hot copy of the phase. Control logic elsewhere combines these lines with the decoded op-code to raise its datapath strobes.

The phase register moves only on the edge that closes slot T3. Instructions that finish in the fetch slots return straight to Fetch. Memory-reference instructions pass through Defer only when their indirect bit is set. The branch instruction falls back to Fetch when its condition fails. A run flip-flop gates all motion. A start request loads (Fetch, T0) and sets the flip-flop. A halt request honoured in (Fetch, T3) clears the flip-flop and parks the sequencer at (Fetch, T0) until the next start.

Top module: `phase_sequencer`

## Requirements
- R1: A low `rst_n` sampled on a rising edge clears the run flip-flop and forces slot T0 with phase Fetch, regardless of what the sequencer was doing.
- R2: `t_phase` always has exactly one bit set; bit k stands for slot Tk.
- R3: While running, the slot moves one step per clock, T0, T1, T2, T3 and back to T0.
- R4: While stopped and with `start` low, both slot and phase hold their values.
- R5: `maj_code` is 00 for Fetch, 01 for Defer and 10 for Execute, never 11. Exactly one of `maj_f`, `maj_d` and `maj_e` is high, and it matches the code.
- R6: The phase never changes on an edge that does not close T3, except through start or reset.
- R7: After Fetch, an op-code whose top two bits are not 01 returns to Fetch.
- R8: After Fetch, an op-code whose top three bits are 011 goes to Defer when `ind_bit` is 1 and to Execute when it is 0. This holds for the branch op-code only when its branch is taken.
- R9: After Fetch, op-codes 01000 to 01011 go to Execute whatever `ind_bit` holds.
- R10: After Fetch, op-code 01111 with `branch_taken` low returns to Fetch.
- R11: Defer is always followed by Execute, and Execute is always followed by Fetch.
- R12: `halt` sampled high in (Fetch, T3) while running stops the sequencer at (Fetch, T0). `halt` in any other slot or phase has no effect.
- R13: `start` while stopped sets the run flip-flop and loads (Fetch, T0); motion begins on the following edge. `start` while running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to start sequencing |
| halt | input | 1 | Halt request, honoured in (Fetch, T3) |
| op_code | input | 5 | Op-code field of the instruction register |
| ind_bit | input | 1 | Indirect-address bit of the instruction |
| branch_taken | input | 1 | Branch condition outcome for the branch op-code |
| t_phase | output | 4 | One-hot slot, bit k = Tk |
| maj_f | output | 1 | Phase is Fetch |
| maj_d | output | 1 | Phase is Defer |
| maj_e | output | 1 | Phase is Execute |
| maj_code | output | 2 | Encoded phase: 00 Fetch, 01 Defer, 10 Execute |

## Verification
The assertions check the invariants on every cycle:
- the slot stays one-hot and rotates while running;
- both states hold while stopped;
- the phase code stays legal and changes only at the close of T3;
- Defer hands over to Execute and Execute to Fetch;
- the rules for halt and start apply.

The op-code routing is left to the bench. Its sweep covers every op-code with both values of the indirect bit and of the branch outcome. Only that sweep shows that each of the 128 combinations takes the right path and the right number of slots. The scenarios also show that stray start and halt requests during a run leave the sequence unchanged.

// File: rtl/seq_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and the phase type for the state sequencer.
// Assumes a 5-bit op-code and a four-slot phase; prefixes set the routing.
package seq_pkg;
    localparam int OP_W    = 5;
    localparam int MINOR_N = 4;
    localparam int CODE_W  = 2;

    // Op-code classes that decide what follows Fetch
    localparam logic [1:0]      EXT_PREFIX = 2'b01;
    localparam logic [2:0]      MEM_PREFIX = 3'b011;
    localparam logic [OP_W-1:0] BR_OPCODE  = 5'b01111;

    typedef enum logic [CODE_W-1:0] {
        PH_FETCH = 2'b00,
        PH_DEFER = 2'b01,
        PH_EXEC  = 2'b10,
        PH_SPARE = 2'b11
    } phase_e;
endpackage

// File: rtl/run_ctrl.sv
`timescale 1ns/1ps
// Run flip-flop. Start sets it only while stopped; halt clears it only
// at the halt point (Fetch, T3). Assumes start and halt are synchronous.
module run_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic halt,
    input  logic halt_point,
    output logic run_q,
    output logic park
);
    logic restart;
    logic stop_now;

    // Decode the two events that reposition the sequencer
    always_comb begin
        restart  = !run_q && start;
        stop_now = run_q && halt && halt_point;
        park     = restart || stop_now;
    end

    // Run flip-flop update
    always_ff @(posedge clk) begin
        if (!rst_n)        run_q <= 1'b0;
        else if (restart)  run_q <= 1'b1;
        else if (stop_now) run_q <= 1'b0;
    end
endmodule

// File: rtl/minor_ring.sv
`timescale 1ns/1ps
// One-hot slot ring of N positions. Rotates on advance and returns to
// slot 0 on park. An illegal pattern also recovers to slot 0.
module minor_ring #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         advance,
    input  logic         park,
    output logic [N-1:0] ring_q,
    output logic         last_slot
);
    localparam logic [N-1:0] HOME = {{(N-1){1'b0}}, 1'b1};

    logic [N-1:0] rotated;
    logic         legal;

    // Each bit takes its lower neighbour; bit 0 takes the top bit
    for (genvar i = 0; i < N; i++) begin : g_rot
        localparam int PREV = (i == 0) ? N - 1 : i - 1;
        assign rotated[i] = ring_q[PREV];
    end

    // Legality of the current ring pattern
    always_comb legal = ($countones(ring_q) == 1);

    // Ring register update
    always_ff @(posedge clk) begin
        if (!rst_n)               ring_q <= HOME;
        else if (park || !legal)  ring_q <= HOME;
        else if (advance)         ring_q <= rotated;
    end

    assign last_slot = ring_q[N-1];
endmodule

// File: rtl/major_fsm.sv
`timescale 1ns/1ps
// Phase register: a mod-3 counter whose step out of Fetch depends on the
// op-code class, the indirect bit and the branch outcome. Steps only on
// step_en (running and last slot). Park forces Fetch.
module major_fsm
    import seq_pkg::*;
#(
    parameter int OPW = OP_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step_en,
    input  logic           park,
    input  logic [OPW-1:0] op_code,
    input  logic           ind_bit,
    input  logic           branch_taken,
    output phase_e         phase_q
);
    phase_e after_fetch;
    phase_e phase_nxt;

    // Route out of Fetch from the op-code class
    always_comb begin
        if (op_code[OPW-1 -: 2] != EXT_PREFIX)
            after_fetch = PH_FETCH;
        else if (op_code == BR_OPCODE && !branch_taken)
            after_fetch = PH_FETCH;
        else if (op_code[OPW-1 -: 3] == MEM_PREFIX)
            after_fetch = ind_bit ? PH_DEFER : PH_EXEC;
        else
            after_fetch = PH_EXEC;
    end

    // Next phase for a step
    always_comb begin
        case (phase_q)
            PH_FETCH: phase_nxt = after_fetch;
            PH_DEFER: phase_nxt = PH_EXEC;
            PH_EXEC:  phase_nxt = PH_FETCH;
            default:  phase_nxt = PH_FETCH;
        endcase
    end

    // Phase register update
    always_ff @(posedge clk) begin
        if (!rst_n)                phase_q <= PH_FETCH;
        else if (park)             phase_q <= PH_FETCH;
        else if (phase_q == PH_SPARE) phase_q <= PH_FETCH;
        else if (step_en)          phase_q <= phase_nxt;
    end
endmodule

// File: rtl/phase_sequencer.sv
`timescale 1ns/1ps
// Top of the major/minor state sequencer. Wires the run flip-flop, the
// slot ring and the phase register, and decodes one-hot phase outputs.
// Assumes all inputs are synchronous to clk.
module phase_sequencer
    import seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                halt,
    input  logic [OP_W-1:0]     op_code,
    input  logic                ind_bit,
    input  logic                branch_taken,
    output logic [MINOR_N-1:0]  t_phase,
    output logic                maj_f,
    output logic                maj_d,
    output logic                maj_e,
    output logic [CODE_W-1:0]   maj_code
);
    logic   run_q;
    logic   park;
    logic   last_slot;
    logic   halt_point;
    logic   step_en;
    phase_e phase_q;

    // Halt point and phase step enable
    always_comb begin
        halt_point = (phase_q == PH_FETCH) && last_slot;
        step_en    = run_q && last_slot;
    end

    run_ctrl u_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .halt       (halt),
        .halt_point (halt_point),
        .run_q      (run_q),
        .park       (park)
    );

    minor_ring #(.N(MINOR_N)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (run_q),
        .park      (park),
        .ring_q    (t_phase),
        .last_slot (last_slot)
    );

    major_fsm #(.OPW(OP_W)) u_major (
        .clk          (clk),
        .rst_n        (rst_n),
        .step_en      (step_en),
        .park         (park),
        .op_code      (op_code),
        .ind_bit      (ind_bit),
        .branch_taken (branch_taken),
        .phase_q      (phase_q)
    );

    // Encoded and one-hot phase outputs
    always_comb begin
        maj_code = phase_q;
        maj_f    = (phase_q == PH_FETCH);
        maj_d    = (phase_q == PH_DEFER);
        maj_e    = (phase_q == PH_EXEC);
    end
endmodule

// File: rtl/phase_sequencer_checker.sv
`timescale 1ns/1ps
// Checker for phase_sequencer: cycle invariants of slot, phase and run state.
module phase_sequencer_checker
    import seq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               halt,
    input logic [MINOR_N-1:0] t_phase,
    input logic               maj_f,
    input logic               maj_d,
    input logic               maj_e,
    input logic [CODE_W-1:0]  maj_code,
    input logic               run_q
);
    assert_slot_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(t_phase));

    assert_slot_rotate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |=> t_phase == {$past(t_phase[MINOR_N-2:0]), $past(t_phase[MINOR_N-1])});

    assert_stopped_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !start) |=> ($stable(t_phase) && $stable(maj_code)));

    assert_phase_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({maj_e, maj_d, maj_f}) && maj_code != 2'b11);

    assert_phase_at_t3_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!t_phase[MINOR_N-1] && !start) |=> $stable(maj_code));

    assert_defer_to_exec_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && t_phase[MINOR_N-1] && maj_d) |=> maj_e);

    assert_exec_to_fetch_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && t_phase[MINOR_N-1] && maj_e) |=> maj_f);

    assert_halt_parks_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && halt && maj_f && t_phase[MINOR_N-1]) |=> (!run_q && t_phase[0] && maj_f));

    assert_start_loads_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && start) |=> (run_q && t_phase[0] && maj_f));
endmodule

bind phase_sequencer phase_sequencer_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .halt     (halt),
    .t_phase  (t_phase),
    .maj_f    (maj_f),
    .maj_d    (maj_d),
    .maj_e    (maj_e),
    .maj_code (maj_code),
    .run_q    (run_q)
);

// File: tb/phase_sequencer_bench.sv
`timescale 1ns/1ps
// Bench: sweeps all op-codes with both indirect and branch values, plus
// reset, halt and start scenarios. Expected paths computed from the rules.
module phase_sequencer_bench;
    localparam int PF = 0, PD = 1, PE = 2;

    logic       clk = 1'b0;
    logic       rst_n, start, halt, ind_bit, branch_taken;
    logic [4:0] op_code;
    logic [3:0] t_phase;
    logic       maj_f, maj_d, maj_e;
    logic [1:0] maj_code;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    phase_sequencer u_phase_sequencer (
        .clk(clk), .rst_n(rst_n), .start(start), .halt(halt),
        .op_code(op_code), .ind_bit(ind_bit), .branch_taken(branch_taken),
        .t_phase(t_phase), .maj_f(maj_f), .maj_d(maj_d), .maj_e(maj_e),
        .maj_code(maj_code)
    );

    // Compare slot and phase (encoded and one-hot) with expectation
    task automatic chk_state(input string req, input int slot, input int ph);
        logic [3:0] exp_t;
        logic [2:0] exp_oh;
        exp_t  = 4'b0001 << slot;
        exp_oh = 3'b001 << ph;
        checks++;
        if (t_phase !== exp_t || maj_code !== 2'(ph) || {maj_e, maj_d, maj_f} !== exp_oh) begin
            errors++;
            $display("FAIL %s: t=%b code=%b oh=%b expected t=%b code=%0d oh=%b",
                     req, t_phase, maj_code, {maj_e, maj_d, maj_f}, exp_t, ph, exp_oh);
        end
    endtask

    // Expected phase after Fetch, from R7..R10
    function automatic int route(input logic [4:0] op, input logic ind, input logic br);
        if (op[4:3] != 2'b01)            return PF;
        if (op == 5'b01111 && !br)       return PF;
        if (op[4:2] == 3'b011)           return ind ? PD : PE;
        return PE;
    endfunction

    // One instruction from (F,T0) back to (F,T0); noise toggles stray start/halt
    task automatic run_instr(input logic [4:0] op, input logic ind, input logic br, input bit noise);
        int cur = PF;
        int nxt;
        string tag = "R3";
        op_code = op; ind_bit = ind; branch_taken = br;
        forever begin
            for (int k = 0; k < 4; k++) begin
                start = noise;
                halt  = noise && (cur != PF);
                chk_state(noise ? {tag, "_R12_R13"} : tag, k, cur);
                @(negedge clk);
            end
            if (cur == PF) begin
                nxt = route(op, ind, br);
                if (op[4:3] != 2'b01)       tag = "R7";
                else if (op == 5'b01111)    tag = "R10";
                else if (op[4:2] == 3'b011) tag = "R8";
                else                        tag = "R9";
            end else begin
                nxt = (cur == PD) ? PE : PF;
                tag = "R11";
            end
            cur = nxt;
            if (cur == PF) break;
        end
        start = 1'b0; halt = 1'b0;
        chk_state({tag, "_R6"}, 0, PF);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; halt = 1'b0;
        op_code = '0; ind_bit = 1'b0; branch_taken = 1'b0;
        repeat (2) @(negedge clk);
        chk_state("R1", 0, PF);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk_state("R4", 0, PF);
        end
        // R13: start loads (F,T0), motion on the next edge
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk_state("R13", 0, PF);
        @(negedge clk); chk_state("R13", 1, PF);
        @(negedge clk); chk_state("R3", 2, PF);
        @(negedge clk); chk_state("R3", 3, PF);
        @(negedge clk); chk_state("R3", 0, PF);
        // Exhaustive routing sweep
        for (int op = 0; op < 32; op++)
            for (int ind = 0; ind < 2; ind++)
                for (int br = 0; br < 2; br++)
                    run_instr(5'(op), 1'(ind), 1'(br), ((op + ind + br) % 3) == 0);
        // R12: halt outside (F,T3) ignored, halt in (F,T3) parks
        op_code = 5'b01100; ind_bit = 1'b1;
        @(negedge clk); halt = 1'b1;
        @(negedge clk); halt = 1'b0; chk_state("R12", 2, PF);
        @(negedge clk); chk_state("R12", 3, PF); halt = 1'b1;
        @(negedge clk); halt = 1'b0; chk_state("R12", 0, PF);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); chk_state("R12", 0, PF);
        end
        // Restart, then reset in the middle of Defer
        start = 1'b1;
        @(negedge clk); start = 1'b0; chk_state("R13", 0, PF);
        @(negedge clk); chk_state("R13", 1, PF);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk); chk_state("R8", 0, PD);
        @(negedge clk); chk_state("R8", 1, PD);
        rst_n = 1'b0;
        @(negedge clk); chk_state("R1", 0, PF);
        rst_n = 1'b1;
        @(negedge clk); chk_state("R4", 0, PF);
        @(negedge clk); chk_state("R4", 0, PF);
        // Halt at (F,T3) on a taken branch that would enter Defer
        op_code = 5'b01111; ind_bit = 1'b1; branch_taken = 1'b1;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk); chk_state("R12", 3, PF); halt = 1'b1;
        @(negedge clk); halt = 1'b0; chk_state("R12", 0, PF);
        @(negedge clk); chk_state("R12", 0, PF);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        #800000;
        if (!done) begin
            errors++;
            $display("FAIL R3: watchdog expired, actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule